// File: doc/BRIEF.md
# ADC Conversion Control and Bus Interface

This block is the digital control side of a sampling analog-to-digital converter's processor interface. A host strobes a conversion-start line while chip select is active. The block then walks a fixed-length conversion through five phases: hold, coarse estimate, and three successive flash passes. When the last pass ends it captures the digital result, raises a done flag and pulls an active-low interrupt.

The host collects the result in one of two ways. In interrupt mode, the result appears on the data bus only while chip select, read and output enable are all low, and a falling read edge clears the interrupt. In fast mode, the bus is driven with the last result at all times, so the host never waits for the interrupt before reading.

The analog sampling and the conversion arithmetic are outside this block. The conversion value arrives on a digital input, and the bus is presented as a data vector plus a drive enable for the pad's tri-state buffer. All four strobes are asynchronous. Each passes through a two-stage synchroniser, and edges are detected on the synchronised levels.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `phase` is 0 (idle), `conv_done` is 0, `irq_n` is 1, `bus_drive` is 0 with `fast_mode` low, and `bus_data` is 0.
- R2: A falling edge on `conv_start_n` while `chip_sel_n` is low and the block is idle starts a conversion on the third rising clock edge after the input changes. On that edge `phase` becomes 1, `conv_done` goes low and `irq_n` goes high.
- R3: A conversion runs through `phase` codes 1 (hold), 2 (estimate), 3 (flash one), 4 (flash two) and 5 (flash three), strictly in that order. Each code lasts exactly STEP_CYC cycles.
- R4: On the edge that ends phase 5, `phase` returns to 0, `conv_done` goes to 1, `irq_n` goes to 0 and `result_in` is captured into `bus_data`. `bus_data` changes at no other time.
- R5: A falling edge on `conv_start_n` during a conversion is ignored: the conversion ends at its original time and no second conversion follows.
- R6: While `chip_sel_n` is high, falling edges on `conv_start_n` and `read_n` have no effect.
- R7: A falling edge on `read_n` while `chip_sel_n` is low sets `irq_n` high on the third edge after the input changes. A `read_n` that is already low when chip select becomes active does not clear it.
- R8: With `fast_mode` low, `bus_drive` is 1 exactly when `chip_sel_n`, `read_n` and `out_en_n` were all low as seen through the synchroniser. It follows the inputs with a three-edge delay.
- R9: With `fast_mode` high, `bus_drive` is 1 from the next edge on, whatever the strobes do, and `bus_data` shows the latest result.
- R10: Starting is edge-triggered: holding `conv_start_n` low after a conversion ends does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low, asynchronous |
| conv_start_n | input | 1 | Conversion start, falling edge acts |
| read_n | input | 1 | Read strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| fast_mode | input | 1 | 1 = bus driven continuously, 0 = read-strobed bus |
| result_in | input | DATA_W | Conversion value from the datapath |
| conv_done | output | 1 | High when a captured result is available |
| irq_n | output | 1 | Active-low result interrupt |
| bus_data | output | DATA_W | Captured result for the data bus |
| bus_drive | output | 1 | Enable for the tri-state bus drivers |
| phase | output | 3 | Current conversion phase code |

## Verification
If the phase counter slips, `phase` shows it at once as a code lasting the wrong number of cycles, and `conv_done` rises on the wrong edge within one conversion. A wrong edge detector or chip-select gate shows up three edges after the strobe: either a conversion that should not start, or an `irq_n` that should not clear. A wrong drive decode appears on `bus_drive` on the third edge after a strobe change. The bench sweeps all eight strobe combinations and many result patterns, and compares against exact cycle counts.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_EST  = 3'd2,
    PH_FL1  = 3'd3,
    PH_FL2  = 3'd4,
    PH_FL3  = 3'd5
  } phase_e;

  localparam int NUM_PHASES = 5;

  function automatic phase_e phase_next(phase_e p);
    case (p)
      PH_HOLD: return PH_EST;
      PH_EST:  return PH_FL1;
      PH_FL1:  return PH_FL2;
      PH_FL2:  return PH_FL3;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/adc_in_sync.sv
// Two-stage synchroniser per strobe plus a falling-edge detector on the
// synchronised level.
module adc_in_sync #(
  parameter int   N       = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_LVL;
        sync_q <= RST_LVL;
        prev_q <= RST_LVL;
      end else begin
        meta_q <= din[gi];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[gi]  = sync_q;
    assign fall[gi] = prev_q & ~sync_q;
  end

endmodule

// File: rtl/adc_step_seq.sv
// Conversion phase sequencer: each phase lasts STEP_CYC cycles.
module adc_step_seq
  import adc_ctrl_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase,
  output logic   done
);

  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc = (cnt_q == CNT_LAST);
  assign done     = (ph_q == PH_FL3) && last_cyc;
  assign phase    = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      cnt_q <= '0;
      if (start) ph_q <= PH_HOLD;
    end else if (last_cyc) begin
      cnt_q <= '0;
      ph_q  <= phase_next(ph_q);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_out_stage.sv
// Result capture, done/interrupt flags and bus drive enable.
module adc_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              done,
  input  logic              rd_clr,
  input  logic              bus_req,
  input  logic              fast_mode,
  input  logic [DATA_W-1:0] result_in,
  output logic              conv_done,
  output logic              irq_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_done <= 1'b0;
      irq_n     <= 1'b1;
      bus_data  <= '0;
      bus_drive <= 1'b0;
    end else begin
      if (done) begin
        conv_done <= 1'b1;
        irq_n     <= 1'b0;
        bus_data  <= result_in;
      end else if (start) begin
        conv_done <= 1'b0;
        irq_n     <= 1'b1;
      end else if (rd_clr) begin
        irq_n <= 1'b1;
      end
      bus_drive <= fast_mode | bus_req;
    end
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              conv_start_n,
  input  logic              read_n,
  input  logic              out_en_n,
  input  logic              fast_mode,
  input  logic [DATA_W-1:0] result_in,
  output logic              conv_done,
  output logic              irq_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive,
  output logic [2:0]        phase
);

  localparam int IX_CS = 0;
  localparam int IX_ST = 1;
  localparam int IX_RD = 2;
  localparam int IX_OE = 3;
  localparam int NSTB  = 4;

  logic [NSTB-1:0] stb_raw, stb_lvl, stb_fall;
  logic            cs_act, start, done, rd_clr, bus_req;
  phase_e          ph;

  assign stb_raw = {out_en_n, read_n, conv_start_n, chip_sel_n};

  adc_in_sync #(.N(NSTB), .RST_LVL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (stb_raw),
    .lvl (stb_lvl),
    .fall(stb_fall)
  );

  assign cs_act  = ~stb_lvl[IX_CS];
  assign start   = stb_fall[IX_ST] & cs_act & (ph == PH_IDLE);
  assign rd_clr  = stb_fall[IX_RD] & cs_act;
  assign bus_req = cs_act & ~stb_lvl[IX_RD] & ~stb_lvl[IX_OE];

  adc_step_seq #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .phase(ph),
    .done (done)
  );

  adc_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .rd_clr   (rd_clr),
    .bus_req  (bus_req),
    .fast_mode(fast_mode),
    .result_in(result_in),
    .conv_done(conv_done),
    .irq_n    (irq_n),
    .bus_data (bus_data),
    .bus_drive(bus_drive)
  );

  assign phase = ph;

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              fast_mode,
  input logic              conv_done,
  input logic              irq_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_drive,
  input logic [2:0]        phase
);

  p_busy_not_done_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd0) |-> !conv_done);

  p_start_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1 && $past(phase) == 3'd0) |-> (irq_n && !conv_done));

  p_phase_order_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) != 3'd0 && phase != $past(phase)) |->
      (phase == (($past(phase) == 3'd5) ? 3'd0 : $past(phase) + 3'd1)));

  p_enter_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == 3'd0 && phase != 3'd0) |-> (phase == 3'd1));

  p_end_flags_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == 3'd5 && phase == 3'd0) |-> (conv_done && !irq_n));

  p_irq_source_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (conv_done && $past(phase) == 3'd5));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$rose(conv_done) |-> $stable(bus_data));

  p_fast_drive_r9: assert property (@(posedge clk) disable iff (rst)
    $past(fast_mode) |-> bus_drive);

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fast_mode(fast_mode),
  .conv_done(conv_done),
  .irq_n    (irq_n),
  .bus_data (bus_data),
  .bus_drive(bus_drive),
  .phase    (phase)
);

// File: tb/test_adc_conv_ctrl.sv
`timescale 1ns/1ps
module test_adc_conv_ctrl;
  localparam int W = 12;
  localparam int S = 4;
  localparam int SYNC_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, st_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, fast = 1'b0;
  logic [W-1:0] res = '0;
  logic done_o, irq_o, drv_o;
  logic [W-1:0] data_o;
  logic [2:0] ph_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_ctrl #(.DATA_W(W), .STEP_CYC(S)) i_adc_conv_ctrl (
    .clk(clk), .rst(rst), .chip_sel_n(cs_n), .conv_start_n(st_n),
    .read_n(rd_n), .out_en_n(oe_n), .fast_mode(fast), .result_in(res),
    .conv_done(done_o), .irq_n(irq_o), .bus_data(data_o),
    .bus_drive(drv_o), .phase(ph_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance n rising edges, then settle 1 ns past the edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // full conversion in the current mode; leaves conv_start_n low
  task automatic run_conv(input logic [W-1:0] val);
    res = val; cs_n = 1'b0; st_n = 1'b0;
    edges(SYNC_LAT);
    chk(ph_o == 3'd1, "R2 phase hold", ph_o, 1);
    chk(!done_o && irq_o, "R2 flags at start", {done_o, irq_o}, 1);
    for (int p = 2; p <= 5; p++) begin
      edges(S);
      chk(ph_o == 3'(p), "R3 phase order", ph_o, p);
    end
    edges(S - 1);
    chk(ph_o == 3'd5 && !done_o, "R3 last flash length", {done_o, ph_o}, 5);
    edges(1);
    chk(ph_o == 3'd0 && done_o && !irq_o, "R4 end flags", {ph_o, done_o, irq_o}, 6'b000_1_0);
  endtask

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    chk(ph_o == 0 && !done_o && irq_o && !drv_o && data_o == 0, "R1 reset state",
        {ph_o, done_o, irq_o, drv_o}, 5'b000_0_1 << 1);

    // R2/R3/R4/R7/R8/R10 over many result patterns, interrupt mode
    for (int k = 0; k < W + 4; k++) begin
      logic [W-1:0] v;
      v = (k < W) ? W'(1) << k : ((k == W) ? '0 : (k == W+1) ? '1 :
          (k == W+2) ? W'(12'h5A5) : W'(12'hA5A));
      run_conv(v);
      edges(2 * S);
      chk(ph_o == 0 && done_o, "R10 held start no retrigger", ph_o, 0);
      chk(!drv_o, "R8 idle bus undriven", drv_o, 0);
      st_n = 1'b1; rd_n = 1'b0; oe_n = 1'b0;
      edges(SYNC_LAT);
      chk(irq_o, "R7 read clears irq", irq_o, 1);
      chk(drv_o && data_o == v, "R4 R8 read data", data_o, v);
      rd_n = 1'b1; oe_n = 1'b1; cs_n = 1'b1;
      edges(SYNC_LAT);
      chk(!drv_o, "R8 release", drv_o, 0);
    end

    // R8 sweep of all strobe combinations
    for (int c = 0; c < 8; c++) begin
      cs_n = c[0]; rd_n = c[1]; oe_n = c[2];
      edges(SYNC_LAT);
      chk(drv_o == (c == 0), "R8 drive decode", drv_o, (c == 0));
      cs_n = 1'b1; rd_n = 1'b1; oe_n = 1'b1;
      edges(SYNC_LAT);
    end

    // R5: second start during a conversion is ignored
    res = 12'h3C3; cs_n = 1'b0; st_n = 1'b0;
    edges(SYNC_LAT + S);
    st_n = 1'b1;
    edges(3);
    st_n = 1'b0;
    edges(SYNC_LAT + 5*S - 1 - (SYNC_LAT + S + 3));
    chk(ph_o == 3'd5 && !done_o, "R5 not restarted", ph_o, 5);
    edges(1);
    chk(done_o && ph_o == 0, "R5 ends on time", {done_o, ph_o}, 4'b1_000);
    edges(2 * S);
    chk(ph_o == 0, "R5 no queued conversion", ph_o, 0);
    st_n = 1'b1;

    // R6: chip select high blocks start and read; R7 level read ignored
    cs_n = 1'b1; edges(SYNC_LAT);
    st_n = 1'b0; rd_n = 1'b0;
    edges(SYNC_LAT + 2);
    chk(ph_o == 0 && done_o, "R6 start blocked", ph_o, 0);
    chk(!irq_o, "R6 read blocked", irq_o, 0);
    chk(!drv_o, "R6 R8 no drive without select", drv_o, 0);
    cs_n = 1'b0;
    edges(SYNC_LAT + 1);
    chk(!irq_o, "R7 held read no clear", irq_o, 0);
    chk(ph_o == 0, "R10 held start with new select", ph_o, 0);
    rd_n = 1'b1; st_n = 1'b1; cs_n = 1'b1;
    edges(SYNC_LAT);

    // R9: fast mode drives continuously and updates with results
    fast = 1'b1;
    edges(1);
    chk(drv_o && data_o == 12'h3C3, "R9 fast drive", data_o, 12'h3C3);
    for (int c = 0; c < 8; c++) begin
      cs_n = c[0]; rd_n = c[1]; oe_n = c[2];
      edges(SYNC_LAT);
      chk(drv_o, "R9 drive any strobes", drv_o, 1);
    end
    cs_n = 1'b1; rd_n = 1'b1; oe_n = 1'b1;
    edges(SYNC_LAT);
    run_conv(12'h9E1);
    chk(drv_o && data_o == 12'h9E1, "R9 new result on bus", data_o, 12'h9E1);
    st_n = 1'b1; cs_n = 1'b1;
    fast = 1'b0;
    edges(2);
    chk(!drv_o, "R8 back to strobed", drv_o, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all R actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule